// File: doc/BRIEF.md
# Packet Page Allocator With Command Decoder

This block owns a small pool of fixed-size packet pages and tracks which of them are in use with one bit per page. It also holds three short first-in first-out lists of page numbers. The transmit list holds pages waiting to be sent. The completion list holds pages whose frames have gone out. The receive list holds pages that carry arrived frames. Software drives the block with byte writes. One write loads a packet-number register. Another write issues a command, whose opcode sits in the top three bits of the byte. The frame side can ask for a receive page, report that the frame at the head of the transmit list has been sent, and drop the head of the completion list.

Allocation always takes the free page with the lowest number. An allocation for transmit that finds no free page does not give up. A two-state controller then waits in `ST_WAIT` with the result reading 0x80, and the next release of any page completes that allocation in the same cycle. The block has two states. `ST_IDLE` means no transmit allocation is waiting. It moves to `ST_WAIT` when an allocate-for-transmit command finds the pool full. `ST_WAIT` returns to `ST_IDLE` in two cases: a release triggers a retry that obtains a page, or the allocator-reset opcode is issued. Event strobes for the allocation-done and receive status bits go to a separate interrupt block. On a single strobe cycle that interrupt block applies a clear before a set.

Commands take effect at the clock edge where `cmd_we` is high. Results, counts and strobes are visible in the following cycle, and each strobe lasts one cycle. Queue heads read 0x80 when their queue is empty; otherwise they read the page number in the low two bits.

Top module: `pkt_page_mmu`

## Requirements
- R1: After reset: alloc_result is 0, no page is used, free_pages is 4, every queue count is 0, every queue head reads 0x80, and no allocation is waiting.
- R2: A command byte whose bits 7:5 equal 1 (allocate for transmit) marks the lowest free page used and loads its number into alloc_result. In the next cycle both ev_alloc_clr and ev_alloc_set pulse.
- R3: When all 4 pages are used, opcode 1 loads 0x80 into alloc_result, pulses only ev_alloc_clr, and leaves the allocation waiting. While alloc_result reads 0x80, free_pages is 0.
- R4: Opcode 5 frees the page named by the low two bits of the packet-number register. If an allocation is waiting, the lowest free page after the release is allocated in the same cycle, loaded into alloc_result, and ev_alloc_set pulses.
- R5: tx_head, done_head and rx_head read 0x80 when their queue is empty. Otherwise they read the oldest entry's page number.
- R6: Opcode 3 pops the receive queue. It pulses ev_rx_set if entries remain and ev_rx_clr if the queue is now empty. Popping an empty queue leaves it unchanged.
- R7: Opcode 4 pops the receive queue and frees the popped page, with the same retry rule as R4. On an empty queue, no page is freed.
- R8: Opcode 6 appends the low two bits of the packet-number register to the transmit queue. An append to a queue that already holds 4 entries is ignored.
- R9: Opcode 7 empties the transmit and completion queues and leaves the page bitmap unchanged.
- R10: Opcode 2 frees every page, empties all three queues, sets alloc_result to 0 and cancels a waiting allocation.
- R11: rx_req in a cycle without cmd_we allocates the lowest free page, appends it to the receive queue, and then pulses rx_ack and ev_rx_set. With no page free, or with cmd_we in the same cycle, only rx_nak pulses and nothing changes.
- R12: tx_sent moves the transmit head into the completion queue, and cmp_pop drops the completion head. Both are ignored in a cycle with cmd_we.
- R13: used_pages counts used pages, free_pages is 4 minus that count, and mem_pages reads 4. Opcode 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command byte write strobe |
| pnum_we | input | 1 | Packet-number byte write strobe |
| wr_data | input | 8 | Write byte; opcode in bits 7:5 for commands |
| rx_req | input | 1 | Frame side requests a receive page |
| tx_sent | input | 1 | Frame at transmit head has been sent |
| cmp_pop | input | 1 | Remove completion-queue head |
| alloc_result | output | 8 | Last transmit allocation result, 0x80 if waiting |
| pkt_num | output | 8 | Packet-number register |
| tx_head | output | 8 | Transmit queue head or 0x80 |
| tx_cnt | output | 3 | Transmit queue occupancy |
| done_head | output | 8 | Completion queue head or 0x80 |
| done_cnt | output | 3 | Completion queue occupancy |
| rx_head | output | 8 | Receive queue head or 0x80 |
| rx_cnt | output | 3 | Receive queue occupancy |
| used_pages | output | 3 | Number of used pages |
| free_pages | output | 3 | Number of free pages |
| mem_pages | output | 8 | Pool size constant |
| ev_alloc_set | output | 1 | Raise allocation-done status |
| ev_alloc_clr | output | 1 | Clear allocation-done status |
| ev_rx_set | output | 1 | Raise receive status |
| ev_rx_clr | output | 1 | Clear receive status |
| rx_ack | output | 1 | Receive page granted |
| rx_nak | output | 1 | Receive page refused |

## Verification
The allocator is tried with a fill-to-full sequence. That sequence separates lowest-free selection from simple counting. A release of a middle page while an allocation waits shows that the retry takes the freed page rather than a stale one. Releases in scrambled order then show that the free map, not a pointer, picks the next page. Receive traffic is tried with two entries, then one, then none, so the set and clear strobes are told apart. The transmit queue is filled past capacity and drained through the completion queue. The bench also issues frame-side inputs in the same cycle as a command, to confirm that they are refused or ignored.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] NO_PAGE = 8'h80;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_TX_ALLOC = 3'd1,
        OP_RESET    = 3'd2,
        OP_RX_POP   = 3'd3,
        OP_RX_FREE  = 3'd4,
        OP_FREE     = 3'd5,
        OP_TX_PUSH  = 3'd6,
        OP_TX_CLEAR = 3'd7
    } mmu_op_e;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } alloc_st_e;
endpackage

// File: rtl/page_bitmap.sv
module page_bitmap #(
    parameter int PAGES = 4,
    localparam int IDX_W = $clog2(PAGES),
    localparam int CNT_W = $clog2(PAGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             rel_en,
    input  logic [IDX_W-1:0] rel_idx,
    input  logic             alloc_en,
    output logic             grant_ok,
    output logic [IDX_W-1:0] grant_idx,
    output logic [CNT_W-1:0] used_cnt
);
    logic [PAGES-1:0] map_q;
    logic [PAGES-1:0] after_rel;
    logic [PAGES-1:0] map_d;

    // free the released page first so a retry can see it
    always_comb begin
        after_rel = map_q;
        if (rel_en) after_rel[rel_idx] = 1'b0;
    end

    // lowest-numbered free page wins
    always_comb begin
        grant_ok  = 1'b0;
        grant_idx = '0;
        for (int i = PAGES - 1; i >= 0; i--) begin
            if (!after_rel[i]) begin
                grant_ok  = 1'b1;
                grant_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        map_d = after_rel;
        if (alloc_en && grant_ok) map_d[grant_idx] = 1'b1;
    end

    always_comb begin
        used_cnt = '0;
        for (int i = 0; i < PAGES; i++) begin
            used_cnt = used_cnt + CNT_W'(map_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) map_q <= '0;
        else               map_q <= map_d;
    end
endmodule

// File: rtl/page_queue.sv
module page_queue #(
    parameter int DEPTH = 4,
    parameter int W = 2,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] cnt
);
    logic [W-1:0]     slot_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic             do_pop;
    logic             do_push;
    logic [PTR_W-1:0] wr_ptr;

    assign do_pop  = pop && (cnt_q != '0);
    assign do_push = push && ((cnt_q != CNT_W'(DEPTH)) || do_pop);
    assign wr_ptr  = PTR_W'(cnt_q - CNT_W'(do_pop));
    assign head    = slot_q[0];
    assign cnt     = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            if (do_pop) begin
                for (int i = 0; i < DEPTH - 1; i++) slot_q[i] <= slot_q[i+1];
            end
            if (do_push) slot_q[wr_ptr] <= push_data;
            cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end
endmodule

// File: rtl/mmu_ctrl.sv
module mmu_ctrl
    import mmu_pkg::*;
#(
    parameter int PAGES = 4,
    localparam int IDX_W = $clog2(PAGES),
    localparam int CNT_W = $clog2(PAGES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              pnum_we,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rx_req,
    input  logic              tx_sent,
    input  logic              cmp_pop,
    input  logic              grant_ok,
    input  logic [IDX_W-1:0]  grant_idx,
    input  logic [CNT_W-1:0]  rx_cnt,
    input  logic [IDX_W-1:0]  rx_head_idx,
    input  logic [CNT_W-1:0]  tx_cnt,
    input  logic [IDX_W-1:0]  tx_head_idx,
    output logic              bm_clr,
    output logic              bm_rel,
    output logic [IDX_W-1:0]  bm_rel_idx,
    output logic              bm_alloc,
    output logic              rxq_clr,
    output logic              rxq_push,
    output logic              rxq_pop,
    output logic              txq_clr,
    output logic              txq_push,
    output logic              txq_pop,
    output logic              cq_clr,
    output logic              cq_push,
    output logic              cq_pop,
    output logic [BYTE_W-1:0] alloc_result,
    output logic [BYTE_W-1:0] pkt_num,
    output logic              ev_alloc_set,
    output logic              ev_alloc_clr,
    output logic              ev_rx_set,
    output logic              ev_rx_clr,
    output logic              rx_ack,
    output logic              rx_nak
);
    alloc_st_e         state_q, state_d;
    mmu_op_e           op;
    logic [BYTE_W-1:0] result_q, result_d;
    logic [BYTE_W-1:0] pnum_q, pnum_d;
    logic              aset_d, aclr_d, rset_d, rclr_d, ack_d, nak_d;
    logic              retry;

    assign op = mmu_op_e'(wr_data[7:5]);

    always_comb begin
        state_d    = state_q;
        result_d   = result_q;
        pnum_d     = pnum_we ? wr_data : pnum_q;
        bm_clr     = 1'b0;
        bm_rel     = 1'b0;
        bm_rel_idx = '0;
        bm_alloc   = 1'b0;
        rxq_clr    = 1'b0;
        rxq_push   = 1'b0;
        rxq_pop    = 1'b0;
        txq_clr    = 1'b0;
        txq_push   = 1'b0;
        txq_pop    = 1'b0;
        cq_clr     = 1'b0;
        cq_push    = 1'b0;
        cq_pop     = 1'b0;
        aset_d     = 1'b0;
        aclr_d     = 1'b0;
        rset_d     = 1'b0;
        rclr_d     = 1'b0;
        ack_d      = 1'b0;
        nak_d      = 1'b0;
        retry      = 1'b0;
        if (cmd_we) begin
            unique case (op)
                OP_NOP: begin
                end
                OP_TX_ALLOC: begin
                    bm_alloc = 1'b1;
                    aclr_d   = 1'b1;
                    if (grant_ok) begin
                        result_d = BYTE_W'(grant_idx);
                        aset_d   = 1'b1;
                        state_d  = ST_IDLE;
                    end else begin
                        result_d = NO_PAGE;
                        state_d  = ST_WAIT;
                    end
                end
                OP_RESET: begin
                    bm_clr   = 1'b1;
                    rxq_clr  = 1'b1;
                    txq_clr  = 1'b1;
                    cq_clr   = 1'b1;
                    result_d = '0;
                    state_d  = ST_IDLE;
                end
                OP_RX_POP: begin
                    rxq_pop = 1'b1;
                    if (rx_cnt > CNT_W'(1)) rset_d = 1'b1;
                    else                    rclr_d = 1'b1;
                end
                OP_RX_FREE: begin
                    rxq_pop = 1'b1;
                    if (rx_cnt > CNT_W'(1)) rset_d = 1'b1;
                    else                    rclr_d = 1'b1;
                    if (rx_cnt != '0) begin
                        bm_rel     = 1'b1;
                        bm_rel_idx = rx_head_idx;
                        retry      = 1'b1;
                    end
                end
                OP_FREE: begin
                    bm_rel     = 1'b1;
                    bm_rel_idx = pnum_q[IDX_W-1:0];
                    retry      = 1'b1;
                end
                OP_TX_PUSH: begin
                    txq_push = 1'b1;
                end
                OP_TX_CLEAR: begin
                    txq_clr = 1'b1;
                    cq_clr  = 1'b1;
                end
            endcase
            // a waiting transmit allocation completes on any release
            if (retry && state_q == ST_WAIT) begin
                bm_alloc = 1'b1;
                if (grant_ok) begin
                    result_d = BYTE_W'(grant_idx);
                    aset_d   = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            if (rx_req) nak_d = 1'b1;
        end else begin
            if (rx_req) begin
                if (grant_ok && rx_cnt != CNT_W'(PAGES)) begin
                    bm_alloc = 1'b1;
                    rxq_push = 1'b1;
                    ack_d    = 1'b1;
                    rset_d   = 1'b1;
                end else begin
                    nak_d = 1'b1;
                end
            end
            if (tx_sent) begin
                txq_pop = 1'b1;
                cq_push = (tx_cnt != '0);
            end
            cq_pop = cmp_pop;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q     <= '0;
            pnum_q       <= '0;
            ev_alloc_set <= 1'b0;
            ev_alloc_clr <= 1'b0;
            ev_rx_set    <= 1'b0;
            ev_rx_clr    <= 1'b0;
            rx_ack       <= 1'b0;
            rx_nak       <= 1'b0;
        end else begin
            result_q     <= result_d;
            pnum_q       <= pnum_d;
            ev_alloc_set <= aset_d;
            ev_alloc_clr <= aclr_d;
            ev_rx_set    <= rset_d;
            ev_rx_clr    <= rclr_d;
            rx_ack       <= ack_d;
            rx_nak       <= nak_d;
        end
    end

    assign alloc_result = result_q;
    assign pkt_num      = pnum_q;
endmodule

// File: rtl/pkt_page_mmu.sv
module pkt_page_mmu
    import mmu_pkg::*;
#(
    parameter int PAGES = 4,
    localparam int IDX_W = $clog2(PAGES),
    localparam int CNT_W = $clog2(PAGES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              pnum_we,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rx_req,
    input  logic              tx_sent,
    input  logic              cmp_pop,
    output logic [BYTE_W-1:0] alloc_result,
    output logic [BYTE_W-1:0] pkt_num,
    output logic [BYTE_W-1:0] tx_head,
    output logic [CNT_W-1:0]  tx_cnt,
    output logic [BYTE_W-1:0] done_head,
    output logic [CNT_W-1:0]  done_cnt,
    output logic [BYTE_W-1:0] rx_head,
    output logic [CNT_W-1:0]  rx_cnt,
    output logic [CNT_W-1:0]  used_pages,
    output logic [CNT_W-1:0]  free_pages,
    output logic [BYTE_W-1:0] mem_pages,
    output logic              ev_alloc_set,
    output logic              ev_alloc_clr,
    output logic              ev_rx_set,
    output logic              ev_rx_clr,
    output logic              rx_ack,
    output logic              rx_nak
);
    logic             bm_clr, bm_rel, bm_alloc, grant_ok;
    logic [IDX_W-1:0] bm_rel_idx, grant_idx;
    logic             rxq_clr, rxq_push, rxq_pop;
    logic             txq_clr, txq_push, txq_pop;
    logic             cq_clr, cq_push, cq_pop;
    logic [IDX_W-1:0] rx_idx, tx_idx, cq_idx;

    page_bitmap #(.PAGES(PAGES)) u_map (
        .clk(clk), .rst_n(rst_n), .clr(bm_clr),
        .rel_en(bm_rel), .rel_idx(bm_rel_idx), .alloc_en(bm_alloc),
        .grant_ok(grant_ok), .grant_idx(grant_idx), .used_cnt(used_pages)
    );

    page_queue #(.DEPTH(PAGES), .W(IDX_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rxq_clr),
        .push(rxq_push), .push_data(grant_idx), .pop(rxq_pop),
        .head(rx_idx), .cnt(rx_cnt)
    );

    page_queue #(.DEPTH(PAGES), .W(IDX_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(txq_clr),
        .push(txq_push), .push_data(pkt_num[IDX_W-1:0]), .pop(txq_pop),
        .head(tx_idx), .cnt(tx_cnt)
    );

    page_queue #(.DEPTH(PAGES), .W(IDX_W)) u_cq (
        .clk(clk), .rst_n(rst_n), .clr(cq_clr),
        .push(cq_push), .push_data(tx_idx), .pop(cq_pop),
        .head(cq_idx), .cnt(done_cnt)
    );

    mmu_ctrl #(.PAGES(PAGES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .pnum_we(pnum_we),
        .wr_data(wr_data), .rx_req(rx_req), .tx_sent(tx_sent), .cmp_pop(cmp_pop),
        .grant_ok(grant_ok), .grant_idx(grant_idx),
        .rx_cnt(rx_cnt), .rx_head_idx(rx_idx), .tx_cnt(tx_cnt), .tx_head_idx(tx_idx),
        .bm_clr(bm_clr), .bm_rel(bm_rel), .bm_rel_idx(bm_rel_idx), .bm_alloc(bm_alloc),
        .rxq_clr(rxq_clr), .rxq_push(rxq_push), .rxq_pop(rxq_pop),
        .txq_clr(txq_clr), .txq_push(txq_push), .txq_pop(txq_pop),
        .cq_clr(cq_clr), .cq_push(cq_push), .cq_pop(cq_pop),
        .alloc_result(alloc_result), .pkt_num(pkt_num),
        .ev_alloc_set(ev_alloc_set), .ev_alloc_clr(ev_alloc_clr),
        .ev_rx_set(ev_rx_set), .ev_rx_clr(ev_rx_clr),
        .rx_ack(rx_ack), .rx_nak(rx_nak)
    );

    assign rx_head    = (rx_cnt   != '0) ? BYTE_W'(rx_idx) : NO_PAGE;
    assign tx_head    = (tx_cnt   != '0) ? BYTE_W'(tx_idx) : NO_PAGE;
    assign done_head  = (done_cnt != '0) ? BYTE_W'(cq_idx) : NO_PAGE;
    assign free_pages = CNT_W'(PAGES) - used_pages;
    assign mem_pages  = BYTE_W'(PAGES);
endmodule

// File: rtl/mmu_checker.sv
module mmu_checker #(
    parameter int PAGES = 4,
    localparam int CNT_W = $clog2(PAGES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_we,
    input logic [7:0]       wr_data,
    input logic             rx_req,
    input logic [7:0]       alloc_result,
    input logic [CNT_W-1:0] used_pages,
    input logic [CNT_W-1:0] free_pages,
    input logic [CNT_W-1:0] rx_cnt,
    input logic [CNT_W-1:0] tx_cnt,
    input logic [CNT_W-1:0] done_cnt,
    input logic             rx_ack,
    input logic             rx_nak
);
    // R2
    alloc_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && wr_data[7:5] == 3'd1 && free_pages != '0)
        |=> (used_pages == $past(used_pages) + 1'b1) && (alloc_result < 8'(PAGES)));

    // R3
    wait_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_result == 8'h80) |-> (free_pages == '0));

    // R8
    txq_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && wr_data[7:5] == 3'd6 && tx_cnt == CNT_W'(PAGES))
        |=> (tx_cnt == CNT_W'(PAGES)));

    // R9
    tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && wr_data[7:5] == 3'd7)
        |=> (tx_cnt == '0) && (done_cnt == '0) && (used_pages == $past(used_pages)));

    // R10
    mmu_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && wr_data[7:5] == 3'd2)
        |=> (used_pages == '0) && (rx_cnt == '0) && (tx_cnt == '0)
            && (done_cnt == '0) && (alloc_result == 8'h00));

    // R11
    rx_resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_ack, rx_nak}));

    // R11
    rx_cmd_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && rx_req) |=> (rx_nak && !rx_ack));
endmodule

bind pkt_page_mmu mmu_checker #(.PAGES(PAGES)) u_mmu_chk (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .wr_data(wr_data), .rx_req(rx_req),
    .alloc_result(alloc_result), .used_pages(used_pages), .free_pages(free_pages),
    .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .done_cnt(done_cnt),
    .rx_ack(rx_ack), .rx_nak(rx_nak)
);

// File: tb/pkt_page_mmu_test.sv
module pkt_page_mmu_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    // vector: cmd byte, packet number, expected result, expected used pages
    localparam logic [26:0] VEC [NVEC] = '{
        {8'h20, 8'h00, 8'h00, 3'd1},
        {8'h20, 8'h00, 8'h01, 3'd2},
        {8'h20, 8'h00, 8'h02, 3'd3},
        {8'h20, 8'h00, 8'h03, 3'd4},
        {8'h20, 8'h00, 8'h80, 3'd4},
        {8'hA0, 8'h02, 8'h02, 3'd4},
        {8'hA0, 8'h00, 8'h02, 3'd3},
        {8'hA0, 8'h01, 8'h02, 3'd2},
        {8'h20, 8'h00, 8'h00, 3'd3},
        {8'h00, 8'h00, 8'h00, 3'd3},
        {8'h40, 8'h00, 8'h00, 3'd0},
        {8'h20, 8'h03, 8'h00, 3'd1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0, pnum_we = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rx_req = 1'b0, tx_sent = 1'b0, cmp_pop = 1'b0;
    logic [7:0] alloc_result, pkt_num, tx_head, done_head, rx_head, mem_pages;
    logic [2:0] tx_cnt, done_cnt, rx_cnt, used_pages, free_pages;
    logic       ev_alloc_set, ev_alloc_clr, ev_rx_set, ev_rx_clr, rx_ack, rx_nak;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_page_mmu uut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .pnum_we(pnum_we), .wr_data(wr_data),
        .rx_req(rx_req), .tx_sent(tx_sent), .cmp_pop(cmp_pop),
        .alloc_result(alloc_result), .pkt_num(pkt_num), .tx_head(tx_head), .tx_cnt(tx_cnt),
        .done_head(done_head), .done_cnt(done_cnt), .rx_head(rx_head), .rx_cnt(rx_cnt),
        .used_pages(used_pages), .free_pages(free_pages), .mem_pages(mem_pages),
        .ev_alloc_set(ev_alloc_set), .ev_alloc_clr(ev_alloc_clr),
        .ev_rx_set(ev_rx_set), .ev_rx_clr(ev_rx_clr), .rx_ack(rx_ack), .rx_nak(rx_nak)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic cw, input logic [7:0] d, input logic pw,
                        input logic rq, input logic ts, input logic cp);
        @(negedge clk);
        cmd_we = cw; wr_data = d; pnum_we = pw; rx_req = rq; tx_sent = ts; cmp_pop = cp;
        @(negedge clk);
        cmd_we = 1'b0; pnum_we = 1'b0; rx_req = 1'b0; tx_sent = 1'b0; cmp_pop = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b);  step(1'b1, b, 1'b0, 1'b0, 1'b0, 1'b0); endtask
    task automatic pnum(input logic [7:0] b); step(1'b0, b, 1'b1, 1'b0, 1'b0, 1'b0); endtask
    task automatic rxr();                     step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 result", alloc_result, 8'h00);
        chk("R1 used", used_pages, 0);
        chk("R1 free", free_pages, 4);
        chk("R13 mem size", mem_pages, 4);
        chk("R1 tx count", tx_cnt, 0);
        chk("R5 tx head empty", tx_head, 8'h80);
        chk("R5 done head empty", done_head, 8'h80);
        chk("R5 rx head empty", rx_head, 8'h80);

        // table walk: R2 R3 R4 R10 R13
        for (int i = 0; i < NVEC; i++) begin
            pnum(VEC[i][18:11]);
            cmd(VEC[i][26:19]);
            chk($sformatf("R2/R4 vector %0d result", i), alloc_result, VEC[i][10:3]);
            chk($sformatf("R13 vector %0d used", i), used_pages, VEC[i][2:0]);
        end

        // R2 strobes
        cmd(8'h40);
        cmd(8'h20);
        chk("R2 set strobe", ev_alloc_set, 1);
        chk("R2 clr strobe", ev_alloc_clr, 1);

        // R11 receive allocation
        rxr();
        chk("R11 ack", rx_ack, 1);
        chk("R11 rx set", ev_rx_set, 1);
        chk("R11 rx head", rx_head, 1);
        rxr();
        chk("R11 fifo order", rx_head, 1);
        chk("R11 rx count", rx_cnt, 2);

        // R6 pop with entries left
        cmd(8'h60);
        chk("R6 head after pop", rx_head, 2);
        chk("R6 set strobe", ev_rx_set, 1);
        chk("R6 no clr strobe", ev_rx_clr, 0);
        chk("R6 pop keeps page", used_pages, 3);

        // R7 pop and release
        cmd(8'h80);
        chk("R7 released", used_pages, 2);
        chk("R7 rx empty head", rx_head, 8'h80);
        chk("R6 clr strobe", ev_rx_clr, 1);
        cmd(8'h80);
        chk("R7 empty no release", used_pages, 2);
        cmd(8'h60);
        chk("R6 empty pop count", rx_cnt, 0);
        chk("R6 empty pop clr", ev_rx_clr, 1);

        // R11 refused alongside a command
        step(1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R11 nak with cmd", rx_nak, 1);
        chk("R11 no alloc with cmd", used_pages, 2);

        // R3 fill and fail
        cmd(8'h20);
        chk("R2 page 2", alloc_result, 2);
        cmd(8'h20);
        chk("R2 page 3", alloc_result, 3);
        rxr();
        chk("R11 nak when full", rx_nak, 1);
        chk("R11 ack when full", rx_ack, 0);
        cmd(8'h20);
        chk("R3 sentinel", alloc_result, 8'h80);
        chk("R3 clr only", ev_alloc_clr, 1);
        chk("R3 no set", ev_alloc_set, 0);
        chk("R13 free zero", free_pages, 0);
        pnum(8'h05);
        cmd(8'hA0);
        chk("R4 retry page", alloc_result, 1);
        chk("R4 retry strobe", ev_alloc_set, 1);
        chk("R4 still full", used_pages, 4);

        // R7 retry through receive release
        cmd(8'h40);
        for (int k = 0; k < 4; k++) rxr();
        chk("R11 four pages", used_pages, 4);
        cmd(8'h20);
        chk("R3 sentinel again", alloc_result, 8'h80);
        cmd(8'h80);
        chk("R7 retry page", alloc_result, 0);
        chk("R7 retry used", used_pages, 4);
        chk("R7 head advanced", rx_head, 1);

        // R8 R12 R9 transmit and completion queues
        cmd(8'h40);
        pnum(8'h03); cmd(8'hC0);
        pnum(8'h01); cmd(8'hC0);
        chk("R8 tx head", tx_head, 3);
        chk("R8 tx count", tx_cnt, 2);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R12 tx head moved", tx_head, 1);
        chk("R12 done head", done_head, 3);
        step(1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R12 sent ignored with cmd", tx_cnt, 1);
        pnum(8'h02);
        cmd(8'hC0); cmd(8'hC0); cmd(8'hC0);
        chk("R8 tx full", tx_cnt, 4);
        cmd(8'hC0);
        chk("R8 full append ignored", tx_cnt, 4);
        chk("R8 head kept", tx_head, 1);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R12 completion pop", done_head, 8'h80);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R12 done head next", done_head, 1);
        cmd(8'h20);
        cmd(8'hE0);
        chk("R9 tx cleared", tx_head, 8'h80);
        chk("R9 done cleared", done_cnt, 0);
        chk("R9 bitmap kept", used_pages, 1);

        // R10 full clear
        rxr();
        pnum(8'h02); cmd(8'hC0);
        cmd(8'h40);
        chk("R10 rx cleared", rx_cnt, 0);
        chk("R10 tx cleared", tx_cnt, 0);
        chk("R10 used cleared", used_pages, 0);
        chk("R10 result", alloc_result, 0);
        chk("R13 pkt num kept", pkt_num, 2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule